// File: doc/BRIEF.md
# SD Field and Line Timing Generator

This block is the timing master for a standard-definition interlaced picture carried on a 27 MHz byte clock. It counts bytes within a line and lines within a frame for either the 525-line (60 Hz) or the 625-line (50 Hz) system. From those counts it derives the horizontal blanking flag H, the field flag F and the vertical blanking flag V. H leaves the block on the horizontal sync pin and F leaves it on the vertical sync pin.

The same counters also compose an embedded-sync byte stream. Each line opens with an end-of-active-video code and then a blanking interval. A start-of-active-video code follows, and the line ends with the active region, where the supplied video bytes are passed through. The codes carry the current F, V and H values, so a downstream receiver can recover the timing from the stream alone.

Inside, a four-state machine walks each line: ST_EAV, ST_HBLANK, ST_SAV and ST_ACTIVE. ST_EAV moves to ST_HBLANK after the last code byte. ST_HBLANK moves to ST_SAV after the last blanking byte. ST_SAV moves to ST_ACTIVE after its last code byte. ST_ACTIVE returns to ST_EAV after the last byte of the line. Reset forces ST_EAV.

Top module: `sd_frame_timer`

## Requirements
- R1: While reset is held low at a clock edge, the block goes to line 1, byte 0, state ST_EAV. It also samples the standard select input then, so the output byte is 0xFF and H is high.
- R2: A line holds 4 code bytes (end of active video), then 268 blanking bytes in 525 mode or 280 in 625 mode, then 4 code bytes (start of active video), then 1440 active bytes. The byte counter is 0-based and returns to 0 after byte 1715 (525) or byte 1727 (625).
- R3: Each code is output as 0xFF, 0x00, 0x00 and then a status byte. The status byte has bit 7 set to 1, bit 6 = F, bit 5 = V and bit 4 = H. H is 1 in the end-of-active code and 0 in the start-of-active code. Bits 3..0 are V^H, F^H, F^V and F^V^H.
- R4: Blanking bytes alternate 0x80 and 0x10. 0x80 falls on even offsets from the first blanking byte.
- R5: In the active region of a line with V=0, the input video byte is output unchanged in the same cycle. On a line with V=1, the active region carries the 0x80/0x10 pattern, in the same phase as the blanking bytes.
- R6: The horizontal sync pin is high from the first byte of the end-of-active code through the last byte of the start-of-active code. It is low for every active byte.
- R7: The line counter is 1-based. It advances on the last byte of a line and wraps from 525 (or 625) back to 1.
- R8: In 525 mode, F=0 on lines 4 to 265 and F=1 on all other lines. V=1 on lines 1 to 19 and 264 to 282.
- R9: In 625 mode, F=0 on lines 1 to 312 and F=1 on lines 313 to 625. V=1 on lines 1 to 22, 311 to 335 and 624 to 625.
- R10: The vertical sync pin carries F, and the V output carries V. Both change only at byte 0 of a line.
- R11: A change on the standard select input in mid-frame does not affect the line length or the flags. It is taken only at the wrap from the last line of the frame to line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_625 | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| vid_in | input | 8 | Active-video byte to be framed |
| hsync_o | output | 1 | H flag |
| vsync_o | output | 1 | F flag |
| vblank_o | output | 1 | V flag |
| line_o | output | LINE_W | Current line number, 1-based |
| byte_o | output | BYTE_W | Current byte position within the line, 0-based |
| data_o | output | 8 | Composed embedded-sync output byte |

## Verification
If the state machine slips out of step with the byte counter, code bytes, blanking pairs or sync edges land on the wrong byte positions. That shows within one line. A wrong line count shows on line_o at once. It also places the F and V transitions on the wrong lines, and those show in the next status byte and on the sync pins. A standard select taken at the wrong moment changes the line length. The byte counter then wraps at the wrong position within the same line.

// File: rtl/sdtg_pkg.sv
package sdtg_pkg;

    typedef enum logic [1:0] {
        ST_EAV,
        ST_HBLANK,
        ST_SAV,
        ST_ACTIVE
    } sdtg_state_e;

    localparam logic [7:0] SYNC_LEAD  = 8'hFF;
    localparam logic [7:0] SYNC_ZERO  = 8'h00;
    localparam logic [7:0] BLANK_CHR  = 8'h80;
    localparam logic [7:0] BLANK_LUMA = 8'h10;

    // 525-line field and vertical-blank boundaries
    localparam int F0_FIRST_525 = 4;
    localparam int F0_LAST_525  = 265;
    localparam int VB1_LAST_525 = 19;
    localparam int VB2_FIRST_525 = 264;
    localparam int VB2_LAST_525  = 282;

    // 625-line field and vertical-blank boundaries
    localparam int F1_FIRST_625  = 313;
    localparam int VB1_LAST_625  = 22;
    localparam int VB2_FIRST_625 = 311;
    localparam int VB2_LAST_625  = 335;
    localparam int VB3_FIRST_625 = 624;

    function automatic logic [7:0] sdtg_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/sdtg_counter.sv
module sdtg_counter #(
    parameter int BYTE_W    = 11,
    parameter int LINE_W    = 10,
    parameter int LEN_525   = 1716,
    parameter int LEN_625   = 1728,
    parameter int LINES_525 = 525,
    parameter int LINES_625 = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_in,
    output logic              std_q,
    output logic [BYTE_W-1:0] byte_q,
    output logic [LINE_W-1:0] line_q,
    output logic              line_end,
    output logic              frame_end
);

    localparam logic [BYTE_W-1:0] LAST_B_525 = BYTE_W'(LEN_525 - 1);
    localparam logic [BYTE_W-1:0] LAST_B_625 = BYTE_W'(LEN_625 - 1);
    localparam logic [LINE_W-1:0] LAST_L_525 = LINE_W'(LINES_525);
    localparam logic [LINE_W-1:0] LAST_L_625 = LINE_W'(LINES_625);
    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    always_comb begin
        line_end  = (byte_q == (std_q ? LAST_B_625 : LAST_B_525));
        frame_end = line_end && (line_q == (std_q ? LAST_L_625 : LAST_L_525));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q  <= std_in;
            byte_q <= '0;
            line_q <= FIRST_LINE;
        end else if (line_end) begin
            byte_q <= '0;
            if (frame_end) begin
                line_q <= FIRST_LINE;
                std_q  <= std_in;
            end else begin
                line_q <= line_q + FIRST_LINE;
            end
        end else begin
            byte_q <= byte_q + BYTE_W'(1);
        end
    end

endmodule

// File: rtl/sdtg_field_decode.sv
module sdtg_field_decode #(
    parameter int LINE_W = 10
) (
    input  logic              std_q,
    input  logic [LINE_W-1:0] line_q,
    output logic              field_f,
    output logic              vblank_v
);

    import sdtg_pkg::*;

    localparam logic [LINE_W-1:0] A_F0_FIRST = LINE_W'(F0_FIRST_525);
    localparam logic [LINE_W-1:0] A_F0_LAST  = LINE_W'(F0_LAST_525);
    localparam logic [LINE_W-1:0] A_VB1_LAST = LINE_W'(VB1_LAST_525);
    localparam logic [LINE_W-1:0] A_VB2_FST  = LINE_W'(VB2_FIRST_525);
    localparam logic [LINE_W-1:0] A_VB2_LAST = LINE_W'(VB2_LAST_525);

    localparam logic [LINE_W-1:0] B_F1_FIRST = LINE_W'(F1_FIRST_625);
    localparam logic [LINE_W-1:0] B_VB1_LAST = LINE_W'(VB1_LAST_625);
    localparam logic [LINE_W-1:0] B_VB2_FST  = LINE_W'(VB2_FIRST_625);
    localparam logic [LINE_W-1:0] B_VB2_LAST = LINE_W'(VB2_LAST_625);
    localparam logic [LINE_W-1:0] B_VB3_FST  = LINE_W'(VB3_FIRST_625);

    logic f_a, v_a, f_b, v_b;

    always_comb begin
        f_a = !((line_q >= A_F0_FIRST) && (line_q <= A_F0_LAST));
        v_a = (line_q <= A_VB1_LAST) ||
              ((line_q >= A_VB2_FST) && (line_q <= A_VB2_LAST));
        f_b = (line_q >= B_F1_FIRST);
        v_b = (line_q <= B_VB1_LAST) ||
              ((line_q >= B_VB2_FST) && (line_q <= B_VB2_LAST)) ||
              (line_q >= B_VB3_FST);
        field_f  = std_q ? f_b : f_a;
        vblank_v = std_q ? v_b : v_a;
    end

endmodule

// File: rtl/sdtg_fsm.sv
module sdtg_fsm #(
    parameter int BYTE_W    = 11,
    parameter int CODE_LEN  = 4,
    parameter int BLANK_525 = 268,
    parameter int BLANK_625 = 280
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     std_q,
    input  logic [BYTE_W-1:0]        byte_q,
    input  logic                     line_end,
    input  logic                     field_f,
    input  logic                     vblank_v,
    input  logic [7:0]               vid_in,
    output sdtg_pkg::sdtg_state_e    state_q,
    output logic                     hsync,
    output logic [7:0]               data
);

    import sdtg_pkg::*;

    localparam logic [BYTE_W-1:0] EAV_FIRST    = '0;
    localparam logic [BYTE_W-1:0] EAV_LAST     = BYTE_W'(CODE_LEN - 1);
    localparam logic [BYTE_W-1:0] HB_LAST_525  = BYTE_W'(CODE_LEN + BLANK_525 - 1);
    localparam logic [BYTE_W-1:0] HB_LAST_625  = BYTE_W'(CODE_LEN + BLANK_625 - 1);
    localparam logic [BYTE_W-1:0] SAV_FST_525  = BYTE_W'(CODE_LEN + BLANK_525);
    localparam logic [BYTE_W-1:0] SAV_FST_625  = BYTE_W'(CODE_LEN + BLANK_625);
    localparam logic [BYTE_W-1:0] SAV_LAST_525 = BYTE_W'(2 * CODE_LEN + BLANK_525 - 1);
    localparam logic [BYTE_W-1:0] SAV_LAST_625 = BYTE_W'(2 * CODE_LEN + BLANK_625 - 1);
    localparam logic              CODE_ODD     = ((CODE_LEN % 2) == 1);

    sdtg_state_e state_d;
    logic [BYTE_W-1:0] hb_last, sav_first, sav_last;
    logic [7:0] blank_pair;

    always_comb begin
        hb_last    = std_q ? HB_LAST_625  : HB_LAST_525;
        sav_first  = std_q ? SAV_FST_625  : SAV_FST_525;
        sav_last   = std_q ? SAV_LAST_625 : SAV_LAST_525;
        blank_pair = (byte_q[0] ^ CODE_ODD) ? BLANK_LUMA : BLANK_CHR;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EAV:    if (byte_q == EAV_LAST) state_d = ST_HBLANK;
            ST_HBLANK: if (byte_q == hb_last)  state_d = ST_SAV;
            ST_SAV:    if (byte_q == sav_last) state_d = ST_ACTIVE;
            ST_ACTIVE: if (line_end)           state_d = ST_EAV;
            default:                           state_d = ST_EAV;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EAV;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        hsync = 1'b1;
        data  = SYNC_ZERO;
        unique case (state_q)
            ST_EAV: begin
                if (byte_q == EAV_FIRST)     data = SYNC_LEAD;
                else if (byte_q == EAV_LAST) data = sdtg_status(field_f, vblank_v, 1'b1);
                else                         data = SYNC_ZERO;
            end
            ST_HBLANK: begin
                data = blank_pair;
            end
            ST_SAV: begin
                if (byte_q == sav_first)     data = SYNC_LEAD;
                else if (byte_q == sav_last) data = sdtg_status(field_f, vblank_v, 1'b0);
                else                         data = SYNC_ZERO;
            end
            ST_ACTIVE: begin
                hsync = 1'b0;
                data  = vblank_v ? blank_pair : vid_in;
            end
            default: begin
                data = SYNC_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/sd_frame_timer.sv
module sd_frame_timer #(
    parameter int ACTIVE_LEN = 1440,
    parameter int CODE_LEN   = 4,
    parameter int BLANK_525  = 268,
    parameter int BLANK_625  = 280,
    parameter int LINES_525  = 525,
    parameter int LINES_625  = 625,
    localparam int LEN_525   = 2 * CODE_LEN + BLANK_525 + ACTIVE_LEN,
    localparam int LEN_625   = 2 * CODE_LEN + BLANK_625 + ACTIVE_LEN,
    localparam int BYTE_W    = $clog2((LEN_625 > LEN_525) ? LEN_625 : LEN_525),
    localparam int LINE_W    = $clog2(((LINES_625 > LINES_525) ? LINES_625 : LINES_525) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_625,
    input  logic [7:0]        vid_in,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              vblank_o,
    output logic [LINE_W-1:0] line_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [7:0]        data_o
);

    sdtg_pkg::sdtg_state_e fsm_state;
    logic std_sel_q;
    logic line_end, frame_end;
    logic field_f, vblank_v;

    sdtg_counter #(
        .BYTE_W    (BYTE_W),
        .LINE_W    (LINE_W),
        .LEN_525   (LEN_525),
        .LEN_625   (LEN_625),
        .LINES_525 (LINES_525),
        .LINES_625 (LINES_625)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_in    (std_625),
        .std_q     (std_sel_q),
        .byte_q    (byte_o),
        .line_q    (line_o),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    sdtg_field_decode #(
        .LINE_W (LINE_W)
    ) u_fld (
        .std_q    (std_sel_q),
        .line_q   (line_o),
        .field_f  (field_f),
        .vblank_v (vblank_v)
    );

    sdtg_fsm #(
        .BYTE_W    (BYTE_W),
        .CODE_LEN  (CODE_LEN),
        .BLANK_525 (BLANK_525),
        .BLANK_625 (BLANK_625)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .std_q    (std_sel_q),
        .byte_q   (byte_o),
        .line_end (line_end),
        .field_f  (field_f),
        .vblank_v (vblank_v),
        .vid_in   (vid_in),
        .state_q  (fsm_state),
        .hsync    (hsync_o),
        .data     (data_o)
    );

    assign vsync_o  = field_f;
    assign vblank_o = vblank_v;

endmodule

// File: rtl/sdtg_checker.sv
module sdtg_checker #(
    parameter int BYTE_W    = 11,
    parameter int LINE_W    = 10,
    parameter int CODE_LEN  = 4,
    parameter int LEN_525   = 1716,
    parameter int LEN_625   = 1728,
    parameter int LINES_525 = 525,
    parameter int LINES_625 = 625
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BYTE_W-1:0]     byte_q,
    input logic [LINE_W-1:0]     line_q,
    input logic                  hsync,
    input logic                  vsync,
    input logic                  vblank,
    input sdtg_pkg::sdtg_state_e state,
    input logic                  std_q
);

    import sdtg_pkg::*;

    localparam logic [BYTE_W-1:0] B_LAST_525 = BYTE_W'(LEN_525 - 1);
    localparam logic [BYTE_W-1:0] B_LAST_625 = BYTE_W'(LEN_625 - 1);
    localparam logic [BYTE_W-1:0] CODE_END   = BYTE_W'(CODE_LEN);
    localparam logic [LINE_W-1:0] N_525      = LINE_W'(LINES_525);
    localparam logic [LINE_W-1:0] N_625      = LINE_W'(LINES_625);
    localparam logic [LINE_W-1:0] ONE_L      = LINE_W'(1);

    logic [BYTE_W-1:0] b_last;
    logic [LINE_W-1:0] n_last;
    logic at_end;

    always_comb begin
        b_last = std_q ? B_LAST_625 : B_LAST_525;
        n_last = std_q ? N_625 : N_525;
        at_end = (byte_q == b_last);
    end

    AST_BYTE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= b_last); // R2
    AST_EAV_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_q < CODE_END) == (state == ST_EAV)); // R2
    AST_ACTIVE_NO_H: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> !hsync); // R6
    AST_BLANK_H: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> hsync); // R6
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && line_q != n_last) |=> (line_q == $past(line_q) + ONE_L)); // R7
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && line_q == n_last) |=> (line_q == ONE_L)); // R7
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q >= ONE_L) && (line_q <= n_last)); // R7
    AST_FLAGS_AT_EAV: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_q != '0) |-> ($stable(vsync) && $stable(vblank))); // R10
    AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_end && line_q == n_last) |=> $stable(std_q)); // R11

endmodule

bind sd_frame_timer sdtg_checker #(
    .BYTE_W    (BYTE_W),
    .LINE_W    (LINE_W),
    .CODE_LEN  (CODE_LEN),
    .LEN_525   (LEN_525),
    .LEN_625   (LEN_625),
    .LINES_525 (LINES_525),
    .LINES_625 (LINES_625)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_q (byte_o),
    .line_q (line_o),
    .hsync  (hsync_o),
    .vsync  (vsync_o),
    .vblank (vblank_o),
    .state  (fsm_state),
    .std_q  (std_sel_q)
);

// File: tb/tb_sd_frame_timer.sv
module tb_sd_frame_timer;

    // short-line instance: 4 + 8 + 4 + 16 = 32 bytes (525), 4 + 12 + 4 + 16 = 36 (625)
    localparam int S_LEN = 32;
    localparam int L_LEN = 36;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       std_s = 1'b0;
    logic       std_f = 1'b0;
    logic [7:0] vid   = 8'h5A;

    logic       hs_s, vs_s, vb_s, hs_f, vs_f, vb_f;
    logic [9:0] line_s, line_f;
    logic [5:0] byte_s;
    logic [10:0] byte_f;
    logic [7:0] data_s, data_f;

    int n_chk = 0;
    int n_err = 0;
    int cur   = 0;

    sd_frame_timer #(
        .ACTIVE_LEN (16),
        .BLANK_525  (8),
        .BLANK_625  (12)
    ) dut (
        .clk (clk), .rst_n (rst_n), .std_625 (std_s), .vid_in (vid),
        .hsync_o (hs_s), .vsync_o (vs_s), .vblank_o (vb_s),
        .line_o (line_s), .byte_o (byte_s), .data_o (data_s)
    );

    sd_frame_timer dut_full (
        .clk (clk), .rst_n (rst_n), .std_625 (std_f), .vid_in (vid),
        .hsync_o (hs_f), .vsync_o (vs_f), .vblank_o (vb_f),
        .line_o (line_f), .byte_o (byte_f), .data_o (data_f)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cur, act, exp);
        end
    endtask

    task automatic goto(input int c);
        while (cur < c) begin
            @(negedge clk);
            cur++;
        end
    endtask

    task automatic restart(input logic s_std, input logic f_std);
        rst_n = 1'b0;
        std_s = s_std;
        std_f = f_std;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = 0;
    endtask

    // {line[9:0], byte[10:0], h, f, v, data[7:0]} for the short 525 instance, vid_in = 0x5A
    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        {10'd1,   11'd0,  1'b1, 1'b1, 1'b1, 8'hFF},
        {10'd1,   11'd3,  1'b1, 1'b1, 1'b1, 8'hF1},
        {10'd1,   11'd4,  1'b1, 1'b1, 1'b1, 8'h80},
        {10'd1,   11'd5,  1'b1, 1'b1, 1'b1, 8'h10},
        {10'd1,   11'd12, 1'b1, 1'b1, 1'b1, 8'hFF},
        {10'd1,   11'd15, 1'b1, 1'b1, 1'b1, 8'hEC},
        {10'd1,   11'd16, 1'b0, 1'b1, 1'b1, 8'h80},
        {10'd1,   11'd17, 1'b0, 1'b1, 1'b1, 8'h10},
        {10'd4,   11'd0,  1'b1, 1'b0, 1'b1, 8'hFF},
        {10'd4,   11'd3,  1'b1, 1'b0, 1'b1, 8'hB6},
        {10'd20,  11'd3,  1'b1, 1'b0, 1'b0, 8'h9D},
        {10'd20,  11'd15, 1'b1, 1'b0, 1'b0, 8'h80},
        {10'd20,  11'd16, 1'b0, 1'b0, 1'b0, 8'h5A},
        {10'd20,  11'd31, 1'b0, 1'b0, 1'b0, 8'h5A},
        {10'd263, 11'd3,  1'b1, 1'b0, 1'b0, 8'h9D},
        {10'd264, 11'd3,  1'b1, 1'b0, 1'b1, 8'hB6},
        {10'd266, 11'd3,  1'b1, 1'b1, 1'b1, 8'hF1},
        {10'd283, 11'd3,  1'b1, 1'b1, 1'b0, 8'hDA},
        {10'd283, 11'd15, 1'b1, 1'b1, 1'b0, 8'hC7},
        {10'd525, 11'd31, 1'b0, 1'b1, 1'b0, 8'h5A}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        // R1: state while reset is held
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 line", line_s, 1);
        chk("R1 byte", byte_s, 0);
        chk("R1 data", data_s, 8'hFF);
        chk("R1 hsync", hs_s, 1);

        // R2: full-size 525 line
        restart(1'b0, 1'b0);
        goto(3);    chk("R3 full status", data_f, 8'hF1);
        goto(271);  chk("R4 full last blank", data_f, 8'h10);
        goto(272);  chk("R2 full sav lead", data_f, 8'hFF);
        goto(275);  chk("R3 full sav status", data_f, 8'hEC);
                    chk("R6 full h in sav", hs_f, 1);
        goto(276);  chk("R6 full h active", hs_f, 0);
                    chk("R5 full vblank active", data_f, 8'h80);
        goto(1715); chk("R2 full last byte", byte_f, 1715);
        goto(1716); chk("R2 full wrap byte", byte_f, 0);
                    chk("R7 full line 2", line_f, 2);

        // R2: full-size 625 line
        restart(1'b0, 1'b1);
        goto(283);  chk("R4 full625 last blank", data_f, 8'h10);
        goto(284);  chk("R2 full625 sav lead", data_f, 8'hFF);
        goto(287);  chk("R3 full625 sav status", data_f, 8'hAB);
        goto(288);  chk("R6 full625 h active", hs_f, 0);
        goto(1727); chk("R2 full625 last byte", byte_f, 1727);
        goto(1728); chk("R7 full625 line 2", line_f, 2);

        // table walk over a 525 frame of the short instance (R3 R6 R7 R8)
        restart(1'b0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            e = VEC[i];
            goto((int'(e[31:22]) - 1) * S_LEN + int'(e[21:11]));
            chk("R7 line", line_s, e[31:22]);
            chk("R2 byte", byte_s, e[21:11]);
            chk("R6 hsync", hs_s, e[10]);
            chk("R8 vsync", vs_s, e[9]);
            chk("R8 vblank", vb_s, e[8]);
            chk("R3 data", data_s, e[7:0]);
        end

        // R7: wrap to line 1
        goto(525 * S_LEN);
        chk("R7 wrap line", line_s, 1);
        chk("R10 vsync after wrap", vs_s, 1);

        // R11: mid-frame select change is ignored
        goto(525 * S_LEN + 40);
        std_s = 1'b1;
        goto(525 * S_LEN + 63);
        chk("R11 old length kept", byte_s, 31);
        goto(525 * S_LEN + 64);
        chk("R11 old length wraps", byte_s, 0);
        chk("R11 line 3", line_s, 3);

        // 625 frame after the next wrap
        base = 2 * 525 * S_LEN;
        goto(base);      chk("R11 625 at wrap", line_s, 1);
                         chk("R9 line1 f", vs_s, 0);
                         chk("R9 line1 v", vb_s, 1);
        goto(base + 3);  chk("R3 625 status", data_s, 8'hB6);
        goto(base + 4);  chk("R4 625 blank first", data_s, 8'h80);
        goto(base + 15); chk("R4 625 blank last", data_s, 8'h10);
        goto(base + 16); chk("R2 625 sav lead", data_s, 8'hFF);
        goto(base + 19); chk("R3 625 sav status", data_s, 8'hAB);
        goto(base + 20); chk("R5 625 v-line active", data_s, 8'h80);
        goto(base + 35); chk("R2 625 last byte", byte_s, 35);
        goto(base + 36); chk("R7 625 line 2", line_s, 2);
        goto(base + 22 * L_LEN + 3);  chk("R9 line23 status", data_s, 8'h9D);
        goto(base + 22 * L_LEN + 20); chk("R5 625 video pass", data_s, 8'h5A);
        goto(base + 310 * L_LEN + 3); chk("R9 line311 status", data_s, 8'hB6);
        goto(base + 311 * L_LEN + 35); chk("R10 line312 end f", vs_s, 0);
        goto(base + 312 * L_LEN);      chk("R10 line313 start f", vs_s, 1);
        goto(base + 312 * L_LEN + 3);  chk("R9 line313 status", data_s, 8'hF1);
        goto(base + 335 * L_LEN + 3);  chk("R9 line336 status", data_s, 8'hDA);
        goto(base + 623 * L_LEN + 3);  chk("R9 line624 status", data_s, 8'hF1);
        goto(base + 625 * L_LEN);      chk("R7 625 wrap", line_s, 1);
                                       chk("R9 wrap f", vs_s, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule